// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block runs on the reference clock and produces a signed frequency-offset word that steers the feedback divider of a clock synthesizer. The offset traces a triangle over one modulation period, which lasts a fixed number of reference cycles. A period-start strobe marks the cycle where the offset sits at its lowest point.

Two three-level spread controls pick one of nine settings: four center-spread amplitudes, four down-spread amplitudes, or no spread at all. A three-level range control sets the period length. A two-bit sub-band input trims the amplitude within the chosen range. All controls are captured once per period, so the offset never jumps in the middle of a sweep.

Top module: `ssm_gen`

## Requirements
- R1: Each three-level control is a 2-bit code: 2'b00 is low, 2'b01 is high, and both 2'b10 and 2'b11 are middle.
- R2: `period_start` is high for exactly one cycle out of every DR cycles. DR is 128 for range low, 256 for range high and 512 for range middle.
- R3: The center-spread codes, written (spread_a, spread_b), are (low,low), (low,mid), (low,high) and (mid,low). For sub-band 0 their peak amplitudes are 140, 120, 60 and 50, in units of 0.01%.
- R4: The down-spread codes are (high,high), (high,low), (mid,high) and (high,mid). For sub-band 0 their depths are 300, 220, 190 and 70, in units of 0.01%.
- R5: Higher sub-bands shrink the amplitude. The center tables for sub-bands 0..3 are {140,130,120,110}, {120,110,90,90}, {60,50,50,40} and {50,40,40,30}. The down tables are {300,270,250,230}, {220,190,180,170}, {190,170,150,140} and {70,60,60,50}. The triangle peak (phase DR/2) reaches +A for center spread and 0 for down spread.
- R6: The setting (mid,mid) turns spreading off, and `offset` stays at 0.
- R7: With center amplitude A, at phase p the offset is floor(2A·t/(DR/2)) − A. Here t = p for p < DR/2 and t = DR − p otherwise. The offset therefore stays within −A..+A and equals −A when `period_start` is high.
- R8: With down depth D, the offset is floor(D·t/(DR/2)) − D. It stays within −D..0 and never goes positive.
- R9: Changes to the controls, the range or the sub-band are captured only in the last cycle of a period. The whole of the next period uses the new setting, and the current period finishes with the old one.
- R10: `rst` is synchronous and active high. While it is asserted, `offset` is 0 and `period_start` is low, and the inputs present are captured as the setting. The cycle after release shows phase 0 with the strobe high. Each output reflects the phase of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_a | input | 2 | First three-level spread control |
| spread_b | input | 2 | Second three-level spread control |
| range_code | input | 2 | Three-level range select, sets DR |
| band | input | 2 | Sub-band trim within the range |
| offset | output | OFF_W | Signed frequency offset, 0.01% units |
| period_start | output | 1 | One-cycle strobe at the start of each period |

## Verification
The assertions assume that the controls are stable around the clock edge and only ever carry defined 2-bit codes, so every decode lands on one of the nine settings. The bench drives new values only on falling edges. It sweeps all three ranges, all nine settings and all four sub-bands, using both middle codes, and it lets each setting run for a full period after it takes hold. It also changes controls and applies reset in mid-period, because the bound assertions only relate the offset to the setting that is already latched.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int AMP_W = 10;
    localparam int LOG_W = 4;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_MID  = 2'd2
    } lvl_t;

    typedef enum logic [1:0] {
        SPR_OFF    = 2'd0,
        SPR_CENTER = 2'd1,
        SPR_DOWN   = 2'd2
    } spr_t;

    typedef struct packed {
        spr_t       mode;
        logic [1:0] idx;
    } sel_t;

    typedef struct packed {
        spr_t             mode;
        logic [AMP_W-1:0] amp;
        logic [LOG_W-1:0] dr_log;
    } prof_cfg_t;

    // Two-bit pin code to level; both upper codes read as middle.
    function automatic lvl_t to_lvl(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_LOW;
            2'b01:   return LVL_HIGH;
            default: return LVL_MID;
        endcase
    endfunction

    function automatic logic [1:0] range_step(input lvl_t l);
        case (l)
            LVL_LOW:  return 2'd0;
            LVL_HIGH: return 2'd1;
            default:  return 2'd2;
        endcase
    endfunction

    // Nine-way decode of the two spread controls.
    function automatic sel_t decode_sel(input lvl_t a, input lvl_t b);
        sel_t s;
        case ({a, b})
            {LVL_LOW,  LVL_LOW }: s = '{SPR_CENTER, 2'd0};
            {LVL_LOW,  LVL_MID }: s = '{SPR_CENTER, 2'd1};
            {LVL_LOW,  LVL_HIGH}: s = '{SPR_CENTER, 2'd2};
            {LVL_MID,  LVL_LOW }: s = '{SPR_CENTER, 2'd3};
            {LVL_HIGH, LVL_HIGH}: s = '{SPR_DOWN,   2'd0};
            {LVL_HIGH, LVL_LOW }: s = '{SPR_DOWN,   2'd1};
            {LVL_MID,  LVL_HIGH}: s = '{SPR_DOWN,   2'd2};
            {LVL_HIGH, LVL_MID }: s = '{SPR_DOWN,   2'd3};
            default:              s = '{SPR_OFF,    2'd0};
        endcase
        return s;
    endfunction

    function automatic logic [AMP_W-1:0] center_amp(input logic [1:0] idx,
                                                     input logic [1:0] sb);
        case ({idx, sb})
            4'h0: return AMP_W'(140);
            4'h1: return AMP_W'(130);
            4'h2: return AMP_W'(120);
            4'h3: return AMP_W'(110);
            4'h4: return AMP_W'(120);
            4'h5: return AMP_W'(110);
            4'h6: return AMP_W'(90);
            4'h7: return AMP_W'(90);
            4'h8: return AMP_W'(60);
            4'h9: return AMP_W'(50);
            4'hA: return AMP_W'(50);
            4'hB: return AMP_W'(40);
            4'hC: return AMP_W'(50);
            4'hD: return AMP_W'(40);
            4'hE: return AMP_W'(40);
            default: return AMP_W'(30);
        endcase
    endfunction

    function automatic logic [AMP_W-1:0] down_amp(input logic [1:0] idx,
                                                   input logic [1:0] sb);
        case ({idx, sb})
            4'h0: return AMP_W'(300);
            4'h1: return AMP_W'(270);
            4'h2: return AMP_W'(250);
            4'h3: return AMP_W'(230);
            4'h4: return AMP_W'(220);
            4'h5: return AMP_W'(190);
            4'h6: return AMP_W'(180);
            4'h7: return AMP_W'(170);
            4'h8: return AMP_W'(190);
            4'h9: return AMP_W'(170);
            4'hA: return AMP_W'(150);
            4'hB: return AMP_W'(140);
            4'hC: return AMP_W'(70);
            4'hD: return AMP_W'(60);
            4'hE: return AMP_W'(60);
            default: return AMP_W'(50);
        endcase
    endfunction

endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
    import ssm_pkg::*;
#(
    parameter int DR_LOG_BASE = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] spread_a,
    input  logic [1:0] spread_b,
    input  logic [1:0] range_code,
    input  logic [1:0] band,
    output prof_cfg_t  cfg_q
);

    sel_t      sel;
    prof_cfg_t cfg_d;

    always_comb begin
        sel         = decode_sel(to_lvl(spread_a), to_lvl(spread_b));
        cfg_d.mode  = sel.mode;
        case (sel.mode)
            SPR_CENTER: cfg_d.amp = center_amp(sel.idx, band);
            SPR_DOWN:   cfg_d.amp = down_amp(sel.idx, band);
            default:    cfg_d.amp = '0;
        endcase
        cfg_d.dr_log = LOG_W'(DR_LOG_BASE) + LOG_W'(range_step(to_lvl(range_code)));
    end

    // Capture only at reset or in the final cycle of a period.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg_q <= cfg_d;
        end
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

endmodule

// File: rtl/ssm_phase.sv
module ssm_phase
    import ssm_pkg::*;
#(
    parameter int PH_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LOG_W-1:0] dr_log,
    output logic [PH_W-1:0]  phase,
    output logic             wrap
);

    logic [PH_W-1:0] last;

    always_comb begin
        last = (PH_W'(1) << dr_log) - PH_W'(1);
        wrap = (phase == last);
    end

    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            phase <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase <= last);

endmodule

// File: rtl/ssm_shape.sv
module ssm_shape
    import ssm_pkg::*;
#(
    parameter int PH_W  = 10,
    parameter int OFF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PH_W-1:0]         phase,
    input  prof_cfg_t               cfg,
    output logic signed [OFF_W-1:0] off_q,
    output logic                    stb_q
);

    localparam int SCL_W  = AMP_W + 1;
    localparam int PROD_W = SCL_W + PH_W;

    logic [LOG_W-1:0]         half_log;
    logic [PH_W-1:0]          dr_len;
    logic [PH_W-1:0]          half_len;
    logic [PH_W-1:0]          tri_v;
    logic [SCL_W-1:0]         scale;
    logic [PROD_W-1:0]        prod;
    logic [PROD_W-1:0]        ramp;
    logic signed [OFF_W-1:0]  level;
    spr_t                     mode_q;
    logic [AMP_W-1:0]         amp_q;
    logic signed [OFF_W-1:0]  amp_s;

    always_comb begin
        half_log = cfg.dr_log - LOG_W'(1);
        dr_len   = PH_W'(1) << cfg.dr_log;
        half_len = PH_W'(1) << half_log;
        tri_v    = (phase < half_len) ? phase : (dr_len - phase);
        scale    = (cfg.mode == SPR_CENTER) ? {cfg.amp, 1'b0} : {1'b0, cfg.amp};
        prod     = PROD_W'(scale) * PROD_W'(tri_v);
        ramp     = prod >> half_log;
        if (cfg.mode == SPR_OFF) begin
            level = '0;
        end else begin
            level = OFF_W'(ramp) - OFF_W'(cfg.amp);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            stb_q  <= 1'b0;
            mode_q <= SPR_OFF;
            amp_q  <= '0;
        end else begin
            off_q  <= level;
            stb_q  <= (phase == '0);
            mode_q <= cfg.mode;
            amp_q  <= cfg.amp;
        end
    end

    assign amp_s = OFF_W'(amp_q);

    // R6
    nospread_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SPR_OFF) |-> (off_q == '0));

    // R7
    center_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SPR_CENTER) |-> (off_q >= -amp_s && off_q <= amp_s));

    // R8
    down_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SPR_DOWN) |-> (off_q >= -amp_s && off_q <= 0));

    // R7
    start_at_min_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_q && mode_q != SPR_OFF) |-> (off_q == -amp_s));

    // R2
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q);

endmodule

// File: rtl/ssm_gen.sv
module ssm_gen
    import ssm_pkg::*;
#(
    parameter int OFF_W       = 16,
    parameter int DR_LOG_BASE = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              spread_a,
    input  logic [1:0]              spread_b,
    input  logic [1:0]              range_code,
    input  logic [1:0]              band,
    output logic signed [OFF_W-1:0] offset,
    output logic                    period_start
);

    localparam int PH_W = DR_LOG_BASE + 3;

    prof_cfg_t       cfg;
    logic [PH_W-1:0] phase;
    logic            wrap;

    ssm_ctrl #(.DR_LOG_BASE(DR_LOG_BASE)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .load       (wrap),
        .spread_a   (spread_a),
        .spread_b   (spread_b),
        .range_code (range_code),
        .band       (band),
        .cfg_q      (cfg)
    );

    ssm_phase #(.PH_W(PH_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .dr_log (cfg.dr_log),
        .phase  (phase),
        .wrap   (wrap)
    );

    ssm_shape #(.PH_W(PH_W), .OFF_W(OFF_W)) u_shape (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .cfg   (cfg),
        .off_q (offset),
        .stb_q (period_start)
    );

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (offset == '0 && !period_start));

endmodule

// File: tb/tb_ssm_gen.sv
module tb_ssm_gen;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst;
    logic [1:0]         sa, sb, rc, bd;
    logic signed [15:0] off;
    logic               stb;

    int checks = 0;
    int errors = 0;
    int m_phase, m_mode, m_amp, m_log;

    int ctab [0:15] = '{140,130,120,110, 120,110,90,90, 60,50,50,40, 50,40,40,30};
    int dtab [0:15] = '{300,270,250,230, 220,190,180,170, 190,170,150,140, 70,60,60,50};

    ssm_gen dut (
        .clk(clk), .rst(rst), .spread_a(sa), .spread_b(sb),
        .range_code(rc), .band(bd), .offset(off), .period_start(stb)
    );

    // 0 low, 1 high, 2 middle (R1)
    function automatic int lv(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b01) return 1;
        return 2;
    endfunction

    task automatic decode(output int mode, output int amp, output int lg);
        int a = lv(sa);
        int b = lv(sb);
        int idx = 0;
        mode = 0;
        if (a == 0 && b == 0) begin mode = 1; idx = 0; end
        if (a == 0 && b == 2) begin mode = 1; idx = 1; end
        if (a == 0 && b == 1) begin mode = 1; idx = 2; end
        if (a == 2 && b == 0) begin mode = 1; idx = 3; end
        if (a == 1 && b == 1) begin mode = 2; idx = 0; end
        if (a == 1 && b == 0) begin mode = 2; idx = 1; end
        if (a == 2 && b == 1) begin mode = 2; idx = 2; end
        if (a == 1 && b == 2) begin mode = 2; idx = 3; end
        amp = (mode == 1) ? ctab[idx*4 + int'(bd)] :
              (mode == 2) ? dtab[idx*4 + int'(bd)] : 0;
        lg = 7 + lv(rc);
    endtask

    task automatic step();
        int pm, pa, pl, dr, h, t, e_off;
        bit e_stb;
        string tag;
        decode(pm, pa, pl);
        if (rst) begin
            e_off = 0; e_stb = 0; tag = "R10";
            m_phase = 0; m_mode = pm; m_amp = pa; m_log = pl;
        end else begin
            dr = 1 << m_log;
            h  = dr / 2;
            t  = (m_phase < h) ? m_phase : dr - m_phase;
            if (m_mode == 1)      e_off = (2 * m_amp * t) / h - m_amp;
            else if (m_mode == 2) e_off = (m_amp * t) / h - m_amp;
            else                  e_off = 0;
            e_stb = (m_phase == 0);
            if (pm != m_mode || pa != m_amp || pl != m_log) tag = "R9";
            else if (m_phase == 0 && m_mode == 1) tag = "R3";
            else if (m_phase == 0 && m_mode == 2) tag = "R4";
            else if (m_phase == h) tag = "R5";
            else if (m_mode == 0) tag = "R6";
            else if (m_mode == 1) tag = "R7";
            else tag = "R8";
            if (m_phase == dr - 1) begin
                m_phase = 0; m_mode = pm; m_amp = pa; m_log = pl;
            end else begin
                m_phase++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (off !== 16'(e_off)) begin
            errors++;
            $display("FAIL %s offset actual %0d expected %0d", tag, off, e_off);
        end
        checks++;
        if (stb !== e_stb) begin
            errors++;
            $display("FAIL R2 strobe actual %0b expected %0b (%s)", stb, e_stb, tag);
        end
    endtask

    task automatic settle_and_run();
        do step(); while (m_phase != 0);
        for (int k = 0; k < (1 << m_log); k++) step();
    endtask

    task automatic strobe_gap(input logic [1:0] code, input int want, input string tag);
        int n = 0;
        rc = code;
        do step(); while (!(m_phase == 1 && m_log == 7 + lv(code)));
        do begin step(); n++; end while (stb !== 1'b1 && n < 2000);
        checks++;
        if (n != want) begin
            errors++;
            $display("FAIL %s strobe spacing actual %0d expected %0d", tag, n, want);
        end
    endtask

    logic [1:0] pa_l [0:8] = '{2'b00,2'b00,2'b00,2'b10,2'b01,2'b01,2'b10,2'b01,2'b10};
    logic [1:0] pb_l [0:8] = '{2'b00,2'b10,2'b01,2'b00,2'b01,2'b00,2'b01,2'b10,2'b10};

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sa = 2'b00; sb = 2'b00; rc = 2'b00; bd = 2'b00;
        @(negedge clk);
        // R10: reset state, then release
        for (int k = 0; k < 3; k++) step();
        rst = 1'b0;
        for (int k = 0; k < 200; k++) step();

        // Exhaustive sweep: range x setting x sub-band (R3 R4 R5 R6 R7 R8; R1 via 2'b11)
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 9; c++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [1:0] mid_c = (s % 2 == 1) ? 2'b11 : 2'b10;
                    rc = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : mid_c;
                    sa = (pa_l[c] == 2'b10) ? mid_c : pa_l[c];
                    sb = (pb_l[c] == 2'b10) ? mid_c : pb_l[c];
                    bd = 2'(s);
                    settle_and_run();
                end
            end
        end

        // R9: mid-period change of setting and range
        sa = 2'b00; sb = 2'b00; rc = 2'b00; bd = 2'b00;
        settle_and_run();
        for (int k = 0; k < 40; k++) step();
        sa = 2'b10; sb = 2'b10;
        for (int k = 0; k < 30; k++) step();
        rc = 2'b01; sa = 2'b01; sb = 2'b01; bd = 2'b11;
        settle_and_run();

        // R10: reset in mid-period
        for (int k = 0; k < 70; k++) step();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        for (int k = 0; k < 300; k++) step();

        // R2 / R1: strobe spacing per range, middle as 2'b11
        strobe_gap(2'b00, 128, "R2");
        strobe_gap(2'b01, 256, "R2");
        strobe_gap(2'b11, 512, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule